// File: doc/BRIEF.md
# Cluster Core Power Sequencer

This block sequences supply and reset for up to four processor cores that share one cluster. Software reaches it through a small 32-bit register bus. To bring a core up, software sets that core's bit in a wake register. The sequencer then turns on the core's supply and waits for the power-good input. It holds the core in reset for a programmed number of cycles and then releases it. When the core is running, the hardware clears the wake bit, so software only has to poll that register until it reads zero.

To take a core down, software first arms a standby request in the core's own control register. Arming changes nothing right away. The power-down starts only when that core next raises its wait-for-interrupt line. The sequencer then puts the core in reset while the supply is still on, turns the supply off, and waits for power-good to fall. At that point it reports standby and clears the armed request. A status word reports each core's state in a 2-bit field. A separate register holds debug reset-enable bits; the sequencer stores them and does not act on them.

Top module: `core_power_ctrl`

## Requirements
- R1: After reset, core 0 is running: power enable 1, reset 0, status code 0. Every other core is in standby: power enable 0, reset 1, status code 3. With four cores the status word reads 0x00003330 and the wake register reads 0.
- R2: Writing the wake register at offset 0x10 with bit n set requests power-up of core n, and writing 0 to a bit has no effect. Bit n reads 1 from the write until the cycle after core n reaches the running state, then reads 0.
- R3: The power-up runs in a fixed order. First power enable rises while reset stays asserted, with status code 1. Reset then stays asserted for exactly RST_HOLD_CYC+1 cycles in which power-good is high. After that reset is released and the code becomes 0. Whenever power enable is low, reset is high.
- R4: The status word at offset 0x40 holds the code of core n in bits [4n+1:4n]. Code 0 means running, 1 powering up, 2 powering down and 3 standby. All other bits read 0.
- R5: A wake request to a core that is already running reads back 0 one cycle after the write.
- R6: Wake bits set for several cores in one write are each serviced, and each of those cores reaches the running state.
- R7: The control register of core n sits at offset 0x100 + 0x10·n. Writing the value 3 arms standby, and the register then reads 3. Writing any other value disarms it, and the register then reads 0. An armed core that does not assert WFI stays running.
- R8: When an armed running core asserts WFI, the next cycle shows code 2 with reset 1 and power enable 1. One cycle later power enable is 0. Once power-good is low the code becomes 3 and the control register reads 0. WFI on a core that is not armed has no effect.
- R9: The debug register at offset 0x180 stores bit 24, bit 19 and bits 20+n for every core n. All other bits read 0.
- R10: Addresses that are not mapped read 0, and writes to the status word change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr_en | input | 1 | Register write strobe |
| bus_addr | input | ADDR_W | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from bus_addr |
| core_wfi | input | NUM_CORES | Wait-for-interrupt from each core |
| core_pgood | input | NUM_CORES | Power-good from each core's supply switch |
| core_pwr_en | output | NUM_CORES | Supply enable for each core |
| core_rst | output | NUM_CORES | Active-high reset for each core |

## Verification
The bench builds the sequencer with the full four cores and RST_HOLD_CYC=5. Using all four cores lets one write wake two cores at once and checks that every status field and every debug enable bit lands in its place. A hold of five cycles, combined with a supply stub that raises power-good three cycles after enable, makes the reset window long enough to count exactly. It also separates the power-up phases clearly from the phases of an overlapping power-down.

// File: rtl/cpc_pkg.sv
package cpc_pkg;

    typedef enum logic [2:0] {
        SEQ_RUN,
        SEQ_PG_WAIT,
        SEQ_RST_HOLD,
        SEQ_DN_RST,
        SEQ_DN_OFF,
        SEQ_STBY
    } seq_state_e;

    typedef logic [1:0] stat_code_t;

    localparam stat_code_t CODE_RUN  = 2'd0;
    localparam stat_code_t CODE_UP   = 2'd1;
    localparam stat_code_t CODE_DOWN = 2'd2;
    localparam stat_code_t CODE_STBY = 2'd3;

    localparam int unsigned OFS_WAKE  = 32'h010;
    localparam int unsigned OFS_STAT  = 32'h040;
    localparam int unsigned OFS_CTL0  = 32'h100;
    localparam int unsigned CTL_PITCH = 32'h010;
    localparam int unsigned OFS_DBG   = 32'h180;

    localparam int unsigned DBG_OTHER_BIT  = 24;
    localparam int unsigned DBG_CORE_LSB   = 20;
    localparam int unsigned DBG_PERIPH_BIT = 19;

    localparam logic [31:0] ARM_VALUE = 32'd3;

    typedef struct packed {
        logic       pwr_en;
        logic       rst;
        stat_code_t code;
        logic       wake_ack;
        logic       stby_ack;
    } seq_out_t;

    function automatic stat_code_t code_of(seq_state_e s);
        case (s)
            SEQ_RUN:                   return CODE_RUN;
            SEQ_PG_WAIT, SEQ_RST_HOLD: return CODE_UP;
            SEQ_DN_RST, SEQ_DN_OFF:    return CODE_DOWN;
            default:                   return CODE_STBY;
        endcase
    endfunction

    function automatic int unsigned ctl_ofs(int unsigned n);
        return OFS_CTL0 + CTL_PITCH * n;
    endfunction

    function automatic logic [31:0] dbg_mask(int unsigned n);
        logic [31:0] m;
        m = '0;
        m[DBG_OTHER_BIT]  = 1'b1;
        m[DBG_PERIPH_BIT] = 1'b1;
        for (int unsigned k = 0; k < n; k++) begin
            m[DBG_CORE_LSB + k] = 1'b1;
        end
        return m;
    endfunction

endpackage

// File: rtl/cpc_core_seq.sv
module cpc_core_seq
    import cpc_pkg::*;
#(
    parameter int unsigned HOLD_CYC = 4,
    parameter bit          BOOT_RUN = 1'b0
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     wake_req,
    input  logic     stby_armed,
    input  logic     wfi,
    input  logic     pgood,
    output seq_out_t out
);

    localparam int unsigned CNT_W = (HOLD_CYC > 1) ? $clog2(HOLD_CYC) : 1;
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(HOLD_CYC - 1);

    seq_state_e       state_q;
    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= BOOT_RUN ? SEQ_RUN : SEQ_STBY;
            cnt_q   <= '0;
        end else begin
            case (state_q)
                SEQ_STBY: begin
                    if (wake_req) state_q <= SEQ_PG_WAIT;
                end
                SEQ_PG_WAIT: begin
                    if (pgood) begin
                        state_q <= SEQ_RST_HOLD;
                        cnt_q   <= '0;
                    end
                end
                SEQ_RST_HOLD: begin
                    if (cnt_q == CNT_LAST) begin
                        state_q <= SEQ_RUN;
                    end else begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
                SEQ_RUN: begin
                    if (stby_armed && wfi) state_q <= SEQ_DN_RST;
                end
                SEQ_DN_RST: begin
                    state_q <= SEQ_DN_OFF;
                end
                SEQ_DN_OFF: begin
                    if (!pgood) state_q <= SEQ_STBY;
                end
                default: state_q <= SEQ_STBY;
            endcase
        end
    end

    always_comb begin
        out.pwr_en   = !((state_q == SEQ_STBY) || (state_q == SEQ_DN_OFF));
        out.rst      = (state_q != SEQ_RUN);
        out.code     = code_of(state_q);
        out.wake_ack = (state_q == SEQ_RUN) && wake_req;
        out.stby_ack = (state_q == SEQ_DN_OFF) && !pgood;
    end

endmodule

// File: rtl/cpc_regs.sv
module cpc_regs
    import cpc_pkg::*;
#(
    parameter int unsigned NUM_CORES = 4,
    parameter int unsigned ADDR_W    = 12
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   bus_wr_en,
    input  logic [ADDR_W-1:0]      bus_addr,
    input  logic [31:0]            bus_wdata,
    output logic [31:0]            bus_rdata,
    input  logic [NUM_CORES-1:0]   wake_ack,
    input  logic [NUM_CORES-1:0]   stby_ack,
    input  logic [2*NUM_CORES-1:0] code_flat,
    output logic [NUM_CORES-1:0]   wake_q,
    output logic [NUM_CORES-1:0]   armed_q
);

    localparam logic [31:0] DBG_MASK = dbg_mask(NUM_CORES);

    logic        hit_wake;
    logic        hit_dbg;
    logic [31:0] dbg_q;
    logic [31:0] stat_word;

    assign hit_wake = bus_wr_en && (bus_addr == ADDR_W'(OFS_WAKE));
    assign hit_dbg  = bus_wr_en && (bus_addr == ADDR_W'(OFS_DBG));

    always_ff @(posedge clk) begin
        if (rst) begin
            wake_q  <= '0;
            armed_q <= '0;
            dbg_q   <= '0;
        end else begin
            for (int i = 0; i < NUM_CORES; i++) begin
                if (hit_wake && bus_wdata[i]) begin
                    wake_q[i] <= 1'b1;
                end else if (wake_ack[i]) begin
                    wake_q[i] <= 1'b0;
                end
                if (bus_wr_en && (bus_addr == ADDR_W'(ctl_ofs(i)))) begin
                    armed_q[i] <= (bus_wdata == ARM_VALUE);
                end else if (stby_ack[i]) begin
                    armed_q[i] <= 1'b0;
                end
            end
            if (hit_dbg) dbg_q <= bus_wdata & DBG_MASK;
        end
    end

    always_comb begin
        stat_word = '0;
        for (int i = 0; i < NUM_CORES; i++) begin
            stat_word[4*i +: 2] = code_flat[2*i +: 2];
        end
    end

    always_comb begin
        bus_rdata = '0;
        if (bus_addr == ADDR_W'(OFS_WAKE)) bus_rdata = 32'(wake_q);
        if (bus_addr == ADDR_W'(OFS_STAT)) bus_rdata = stat_word;
        if (bus_addr == ADDR_W'(OFS_DBG))  bus_rdata = dbg_q;
        for (int i = 0; i < NUM_CORES; i++) begin
            if (bus_addr == ADDR_W'(ctl_ofs(i))) begin
                bus_rdata = {30'b0, {2{armed_q[i]}}};
            end
        end
    end

endmodule

// File: rtl/core_power_ctrl.sv
module core_power_ctrl
    import cpc_pkg::*;
#(
    parameter int unsigned NUM_CORES    = 4,
    parameter int unsigned ADDR_W       = 12,
    parameter int unsigned RST_HOLD_CYC = 4
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 bus_wr_en,
    input  logic [ADDR_W-1:0]    bus_addr,
    input  logic [31:0]          bus_wdata,
    output logic [31:0]          bus_rdata,
    input  logic [NUM_CORES-1:0] core_wfi,
    input  logic [NUM_CORES-1:0] core_pgood,
    output logic [NUM_CORES-1:0] core_pwr_en,
    output logic [NUM_CORES-1:0] core_rst
);

    logic [NUM_CORES-1:0]   wake_q;
    logic [NUM_CORES-1:0]   armed_q;
    logic [NUM_CORES-1:0]   wake_ack;
    logic [NUM_CORES-1:0]   stby_ack;
    logic [2*NUM_CORES-1:0] code_flat;

    cpc_regs #(
        .NUM_CORES (NUM_CORES),
        .ADDR_W    (ADDR_W)
    ) u_regs (
        .clk       (clk),
        .rst       (rst),
        .bus_wr_en (bus_wr_en),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .wake_ack  (wake_ack),
        .stby_ack  (stby_ack),
        .code_flat (code_flat),
        .wake_q    (wake_q),
        .armed_q   (armed_q)
    );

    for (genvar g = 0; g < NUM_CORES; g++) begin : g_core
        seq_out_t so;

        cpc_core_seq #(
            .HOLD_CYC (RST_HOLD_CYC),
            .BOOT_RUN (g == 0)
        ) u_seq (
            .clk        (clk),
            .rst        (rst),
            .wake_req   (wake_q[g]),
            .stby_armed (armed_q[g]),
            .wfi        (core_wfi[g]),
            .pgood      (core_pgood[g]),
            .out        (so)
        );

        assign core_pwr_en[g]     = so.pwr_en;
        assign core_rst[g]        = so.rst;
        assign code_flat[2*g +: 2] = so.code;
        assign wake_ack[g]        = so.wake_ack;
        assign stby_ack[g]        = so.stby_ack;
    end

endmodule

// File: rtl/cpc_checker.sv
module cpc_checker #(
    parameter int unsigned NUM_CORES = 4,
    parameter int unsigned ADDR_W    = 12
) (
    input logic                   clk,
    input logic                   rst,
    input logic                   bus_wr_en,
    input logic [ADDR_W-1:0]      bus_addr,
    input logic [31:0]            bus_wdata,
    input logic [NUM_CORES-1:0]   core_pwr_en,
    input logic [NUM_CORES-1:0]   core_rst,
    input logic [NUM_CORES-1:0]   wake_q,
    input logic [NUM_CORES-1:0]   armed_q,
    input logic [2*NUM_CORES-1:0] code_flat
);

    logic wake_wr;
    assign wake_wr = bus_wr_en && (bus_addr == ADDR_W'(32'h010));

    for (genvar g = 0; g < NUM_CORES; g++) begin : g_chk
        // R3
        pwr_off_rst_chk: assert property (@(posedge clk) disable iff (rst)
            !core_pwr_en[g] |-> core_rst[g]);

        // R4
        stby_unpowered_chk: assert property (@(posedge clk) disable iff (rst)
            (code_flat[2*g +: 2] == 2'd3) |-> !core_pwr_en[g]);

        // R4
        run_released_chk: assert property (@(posedge clk) disable iff (rst)
            (code_flat[2*g +: 2] == 2'd0) |-> (core_pwr_en[g] && !core_rst[g]));

        // R5
        wake_running_clear_chk: assert property (@(posedge clk) disable iff (rst)
            ((code_flat[2*g +: 2] == 2'd0) && wake_q[g] && !(wake_wr && bus_wdata[g]))
            |=> !wake_q[g]);

        // R8
        unarmed_stays_chk: assert property (@(posedge clk) disable iff (rst)
            ((code_flat[2*g +: 2] == 2'd0) && !armed_q[g])
            |=> (code_flat[2*g +: 2] != 2'd2));
    end

endmodule

bind core_power_ctrl cpc_checker #(
    .NUM_CORES (NUM_CORES),
    .ADDR_W    (ADDR_W)
) chk_i (
    .clk         (clk),
    .rst         (rst),
    .bus_wr_en   (bus_wr_en),
    .bus_addr    (bus_addr),
    .bus_wdata   (bus_wdata),
    .core_pwr_en (core_pwr_en),
    .core_rst    (core_rst),
    .wake_q      (wake_q),
    .armed_q     (armed_q),
    .code_flat   (code_flat)
);

// File: tb/core_power_ctrl_tb_top.sv
module core_power_ctrl_tb_top;

    localparam int NC     = 4;
    localparam int AW     = 12;
    localparam int HOLD   = 5;
    localparam int PG_DLY = 3;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          bus_wr_en = 1'b0;
    logic [AW-1:0] bus_addr = '0;
    logic [31:0]   bus_wdata = '0;
    logic [31:0]   bus_rdata;
    logic [NC-1:0] core_wfi = '0;
    logic [NC-1:0] core_pgood;
    logic [NC-1:0] core_pwr_en;
    logic [NC-1:0] core_rst;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    core_power_ctrl #(
        .NUM_CORES    (NC),
        .ADDR_W       (AW),
        .RST_HOLD_CYC (HOLD)
    ) dut_i (
        .clk         (clk),
        .rst         (rst),
        .bus_wr_en   (bus_wr_en),
        .bus_addr    (bus_addr),
        .bus_wdata   (bus_wdata),
        .bus_rdata   (bus_rdata),
        .core_wfi    (core_wfi),
        .core_pgood  (core_pgood),
        .core_pwr_en (core_pwr_en),
        .core_rst    (core_rst)
    );

    // supply switch stub: power-good follows enable after PG_DLY cycles
    logic [NC-1:0] pg_pipe [PG_DLY];
    initial for (int k = 0; k < PG_DLY; k++) pg_pipe[k] = '0;
    always @(posedge clk) begin
        pg_pipe[0] <= core_pwr_en;
        for (int k = 1; k < PG_DLY; k++) pg_pipe[k] <= pg_pipe[k-1];
    end
    assign core_pgood = pg_pipe[PG_DLY-1];

    task automatic check(input bit ok, input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [AW-1:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr_en = 1'b1;
        bus_addr  = a;
        bus_wdata = d;
        @(negedge clk);
        bus_wr_en = 1'b0;
    endtask

    task automatic bus_read(input logic [AW-1:0] a, output logic [31:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    function automatic logic [1:0] field(input logic [31:0] s, input int n);
        return s[4*n +: 2];
    endfunction

    task automatic t_reset();
        logic [31:0] d;
        bus_read(12'h040, d);
        check(d == 32'h3330, "R1 status", d, 32'h3330);
        bus_read(12'h010, d);
        check(d == 0, "R1 wake", d, 0);
        check(core_pwr_en == 4'b0001, "R1 pwr_en", 32'(core_pwr_en), 1);
        check(core_rst == 4'b1110, "R1 rst", 32'(core_rst), 32'he);
    endtask

    task automatic t_wake_running();
        logic [31:0] d;
        bus_write(12'h010, 32'h1);
        @(negedge clk);
        bus_read(12'h010, d);
        check(d == 0, "R5 running wake clears", d, 0);
    endtask

    task automatic t_write_zero();
        logic [31:0] d;
        bus_write(12'h010, 32'h0);
        repeat (4) @(negedge clk);
        bus_read(12'h010, d);
        check(d == 0, "R2 zero write wake", d, 0);
        bus_read(12'h040, d);
        check(field(d, 3) == 2'd3, "R2 zero write leaves core3", 32'(field(d, 3)), 3);
    endtask

    task automatic t_wake_one(input int n);
        logic [31:0] d, s;
        int hold_cnt = 0;
        bit saw_up = 0, order_ok = 1, done = 0;
        bus_write(12'h010, 32'(1 << n));
        bus_read(12'h010, d);
        check(d[n] == 1'b1, "R2 wake bit set", d, 32'(1 << n));
        for (int c = 0; c < 100 && !done; c++) begin
            @(negedge clk);
            bus_read(12'h040, s);
            if (field(s, n) == 2'd1) begin
                saw_up = 1;
                if (!(core_pwr_en[n] && core_rst[n])) order_ok = 0;
            end
            if (core_pgood[n] && core_rst[n]) hold_cnt++;
            bus_read(12'h010, d);
            if (d[n] == 1'b0) done = 1;
        end
        check(done, "R2 wake self-clears", d, 0);
        check(saw_up && order_ok, "R3 up code with pwr on and reset held",
              32'(order_ok), 1);
        check(hold_cnt == HOLD + 1, "R3 reset hold window", hold_cnt, HOLD + 1);
        check(field(s, n) == 2'd0 && core_pwr_en[n] && !core_rst[n],
              "R3 running after power-up", 32'(field(s, n)), 0);
    endtask

    task automatic t_wake_multi();
        logic [31:0] d, s;
        bit done = 0;
        bus_write(12'h010, 32'h000a);
        for (int c = 0; c < 100 && !done; c++) begin
            @(negedge clk);
            bus_read(12'h010, d);
            if (d == 0) done = 1;
        end
        bus_read(12'h040, s);
        check(done && s == 32'h0000, "R6 two cores woken together", s, 32'h0000);
        check(core_pwr_en == 4'b1111 && core_rst == 4'b0000, "R6 outputs",
              32'({core_pwr_en, core_rst}), 32'hf0);
    endtask

    task automatic t_standby(input int n);
        logic [31:0] d, s;
        logic [AW-1:0] ca;
        bit done = 0;
        ca = AW'(32'h100 + 32'h10 * n);
        bus_write(ca, 32'd3);
        bus_read(ca, d);
        check(d == 3, "R7 armed reads 3", d, 3);
        repeat (6) @(negedge clk);
        bus_read(12'h040, s);
        check(field(s, n) == 2'd0, "R7 armed without WFI stays running",
              32'(field(s, n)), 0);
        core_wfi[n] = 1'b1;
        @(negedge clk);
        core_wfi[n] = 1'b0;
        bus_read(12'h040, s);
        check(field(s, n) == 2'd2 && core_rst[n] && core_pwr_en[n],
              "R8 reset first with power on", {s[15:0], 14'b0, core_rst[n], core_pwr_en[n]},
              {16'(32'h2 << (4 * n)), 16'h0003});
        @(negedge clk);
        check(!core_pwr_en[n] && core_rst[n], "R8 power dropped after reset",
              32'({core_pwr_en[n], core_rst[n]}), 1);
        for (int c = 0; c < 50 && !done; c++) begin
            bus_read(12'h040, s);
            if (field(s, n) == 2'd3) done = 1;
            else @(negedge clk);
        end
        bus_read(ca, d);
        check(done && d == 0, "R8 standby reached and arm cleared", d, 0);
    endtask

    task automatic t_unarmed_wfi();
        logic [31:0] d, s;
        bus_write(12'h110, 32'd3);
        bus_write(12'h110, 32'd1);
        bus_read(12'h110, d);
        check(d == 0, "R7 other value disarms", d, 0);
        core_wfi = 4'b0011;
        @(negedge clk);
        core_wfi = '0;
        repeat (5) @(negedge clk);
        bus_read(12'h040, s);
        check(field(s, 0) == 0 && field(s, 1) == 0 && core_pwr_en[1:0] == 2'b11,
              "R8 WFI without arm ignored", s[7:0], 0);
    endtask

    task automatic t_debug();
        logic [31:0] d;
        bus_write(12'h180, 32'hffff_ffff);
        bus_read(12'h180, d);
        check(d == 32'h01f8_0000, "R9 debug bits", d, 32'h01f8_0000);
        bus_write(12'h180, 32'h0010_0000);
        bus_read(12'h180, d);
        check(d == 32'h0010_0000, "R9 debug single bit", d, 32'h0010_0000);
    endtask

    task automatic t_unmapped();
        logic [31:0] d, s0, s1;
        bus_read(12'h044, d);
        check(d == 0, "R10 unmapped 0x044", d, 0);
        bus_read(12'h1c0, d);
        check(d == 0, "R10 unmapped 0x1c0", d, 0);
        bus_read(12'h040, s0);
        bus_write(12'h040, 32'hffff_ffff);
        @(negedge clk);
        bus_read(12'h040, s1);
        check(s1 == s0 && (s1 & 32'hffff_cccc) == 0, "R10 R4 status unwritable", s1, s0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        repeat (6) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_wake_running();
        t_write_zero();
        t_wake_one(2);
        t_wake_multi();
        t_standby(2);
        t_wake_one(2);
        t_unarmed_wfi();
        t_debug();
        t_unmapped();
        finished = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule